// File: doc/BRIEF.md
# Four-Point Signed Coordinate Cross Comparator

This block takes four signed coordinates that all lie on one axis and compares every ordered pair of them. It returns three 16-bit status words: one for equality, one for greater-than and one for less-than. A shape-drawing sequencer reads these words before it starts drawing. From them it can work out the vertex order of a triangle. It can also tell when the vertices collapse into a single point or into an axis-aligned line, and it can pick the count direction of each edge walker. A design that needs both axes instantiates the block twice.

An elaboration-time bit parameter selects the output style. In the registered style the status words are captured on the clock. The capture happens only while the update enable is high, and that enable is normally driven by the inverse of the downstream drawing-busy signal. In the combinational style the words follow the inputs directly.

Top module: `quad_coord_compare`

## Requirements
- R1: Coordinate k occupies bits [k*12+11 : k*12] of `pts`. Status bit i compares coordinate i[3:2], the left operand, against coordinate i[1:0], the right operand.
- R2: An `eq_word` bit is 1 exactly when its two coordinates are equal.
- R3: A `gt_word` bit is 1 exactly when the left coordinate is greater than the right one, comparing as two's-complement signed values.
- R4: A `lt_word` bit is 1 exactly when the left coordinate is less than the right one, comparing as signed values. Any negative coordinate is less than any coordinate that is zero or positive.
- R5: For each bit position of a valid comparison, exactly one of eq, gt and lt is 1.
- R6: The self-comparison bits 0, 5, 10 and 15 always read eq=1, gt=0 and lt=0.
- R7: Bit a*4+b of `gt_word` equals bit b*4+a of `lt_word`.
- R8: With REGISTERED=1 and `upd_en` high at a rising edge, the outputs show the comparison of the inputs sampled at that edge, one cycle after the inputs were applied.
- R9: With REGISTERED=1 and `upd_en` low at a rising edge, all three outputs keep their previous values, whatever the inputs do.
- R10: With REGISTERED=1, `rst` high at a rising edge clears all three words to zero. Reset takes priority over `upd_en`.
- R11: With REGISTERED=0, the outputs follow the inputs combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered style |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Capture enable for the registered style |
| pts | input | 48 | Four packed signed 12-bit coordinates |
| eq_word | output | 16 | Pairwise equality flags |
| gt_word | output | 16 | Pairwise greater-than flags |
| lt_word | output | 16 | Pairwise less-than flags |

## Verification
A wrong comparison shows at the ports in the first cycle that feeds a pair which exposes it. For example, a signedness error shows up as soon as a negative coordinate is compared against a positive one. A capture register that is corrupted, or that ignores the enable, shows a mismatch at the first sample after that edge. A register that misses a reset shows nonzero words in the cycle right after reset. The bench compares both output styles against a behavioural model every cycle. It also checks the one-hot, diagonal and mirror relations directly on the outputs.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } rel_t;

  function automatic int unsigned left_of(input int unsigned bitpos, input int unsigned npts);
    return bitpos / npts;
  endfunction

  function automatic int unsigned right_of(input int unsigned bitpos, input int unsigned npts);
    return bitpos % npts;
  endfunction

endpackage

// File: rtl/qcc_pair_rel.sv
module qcc_pair_rel
  import qcc_pkg::*;
#(
  parameter int unsigned COORD_W = 12
) (
  input  logic signed [COORD_W-1:0] lhs,
  input  logic signed [COORD_W-1:0] rhs,
  output rel_t                      rel
);

  always_comb begin
    rel.eq = (lhs == rhs);
    rel.gt = (lhs > rhs);
    rel.lt = (lhs < rhs);
  end

  // R5: exactly one relation holds for a pair of known values
  always_comb begin
    if (!$isunknown({lhs, rhs}))
      assert_one_rel_R5: assert ($countones({rel.eq, rel.gt, rel.lt}) == 1);
  end

endmodule

// File: rtl/qcc_out_stage.sv
module qcc_out_stage #(
  parameter int unsigned PAIRS      = 16,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [PAIRS-1:0] d_eq,
  input  logic [PAIRS-1:0] d_gt,
  input  logic [PAIRS-1:0] d_lt,
  output logic [PAIRS-1:0] q_eq,
  output logic [PAIRS-1:0] q_gt,
  output logic [PAIRS-1:0] q_lt
);

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q_eq <= '0;
          q_gt <= '0;
          q_lt <= '0;
        end else if (upd_en) begin
          q_eq <= d_eq;
          q_gt <= d_gt;
          q_lt <= d_lt;
        end
      end

      assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (q_eq == '0 && q_gt == '0 && q_lt == '0));

      assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (q_eq == $past(d_eq) && q_gt == $past(d_gt) && q_lt == $past(d_lt)));

      assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> ($stable(q_eq) && $stable(q_gt) && $stable(q_lt)));
    end else begin : g_comb
      assign q_eq = d_eq;
      assign q_gt = d_gt;
      assign q_lt = d_lt;
    end
  endgenerate

endmodule

// File: rtl/quad_coord_compare.sv
module quad_coord_compare
  import qcc_pkg::*;
#(
  parameter int unsigned COORD_W    = 12,
  parameter int unsigned NUM_PTS    = 4,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         upd_en,
  input  logic [NUM_PTS*COORD_W-1:0]   pts,
  output logic [NUM_PTS*NUM_PTS-1:0]   eq_word,
  output logic [NUM_PTS*NUM_PTS-1:0]   gt_word,
  output logic [NUM_PTS*NUM_PTS-1:0]   lt_word
);

  localparam int unsigned PAIRS = NUM_PTS * NUM_PTS;

  logic [PAIRS-1:0] raw_eq;
  logic [PAIRS-1:0] raw_gt;
  logic [PAIRS-1:0] raw_lt;

  // R1: status bit p compares point p/NUM_PTS against point p%NUM_PTS
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int unsigned L_IDX = left_of(p, NUM_PTS);
    localparam int unsigned R_IDX = right_of(p, NUM_PTS);
    rel_t rel;

    qcc_pair_rel #(.COORD_W(COORD_W)) u_rel (
      .lhs (pts[L_IDX*COORD_W +: COORD_W]),
      .rhs (pts[R_IDX*COORD_W +: COORD_W]),
      .rel (rel)
    );

    assign raw_eq[p] = rel.eq;
    assign raw_gt[p] = rel.gt;
    assign raw_lt[p] = rel.lt;
  end

  qcc_out_stage #(.PAIRS(PAIRS), .REGISTERED(REGISTERED)) u_out (
    .clk    (clk),
    .rst    (rst),
    .upd_en (upd_en),
    .d_eq   (raw_eq),
    .d_gt   (raw_gt),
    .d_lt   (raw_lt),
    .q_eq   (eq_word),
    .q_gt   (gt_word),
    .q_lt   (lt_word)
  );

  // R6 and R7: relations across separately built pair comparators
  always_comb begin
    if (!$isunknown(pts)) begin
      for (int a = 0; a < NUM_PTS; a++) begin
        assert_diag_equal_R6: assert (raw_eq[a*NUM_PTS+a] && !raw_gt[a*NUM_PTS+a] && !raw_lt[a*NUM_PTS+a]);
        for (int b = 0; b < NUM_PTS; b++) begin
          assert_mirror_R7: assert (raw_gt[a*NUM_PTS+b] == raw_lt[b*NUM_PTS+a]);
        end
      end
    end
  end

endmodule

// File: tb/tb_quad_coord_compare.sv
module tb_quad_coord_compare;

  localparam int W = 12;
  localparam int N = 4;
  localparam int P = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         upd_en = 1'b0;
  logic [N*W-1:0] pts = '0;
  logic [P-1:0] eq_r, gt_r, lt_r;
  logic [P-1:0] eq_c, gt_c, lt_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_coord_compare #(.COORD_W(W), .NUM_PTS(N), .REGISTERED(1'b1)) dut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .pts(pts),
    .eq_word(eq_r), .gt_word(gt_r), .lt_word(lt_r));

  quad_coord_compare #(.COORD_W(W), .NUM_PTS(N), .REGISTERED(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .upd_en(upd_en), .pts(pts),
    .eq_word(eq_c), .gt_word(gt_c), .lt_word(lt_c));

  // behavioural reference
  task automatic ref_words(input logic [N*W-1:0] c, output logic [P-1:0] e,
                           output logic [P-1:0] g, output logic [P-1:0] l);
    int v [N];
    for (int k = 0; k < N; k++) v[k] = int'($signed(c[k*W +: W]));
    for (int i = 0; i < P; i++) begin
      e[i] = (v[i/N] == v[i%N]);
      g[i] = (v[i/N] >  v[i%N]);
      l[i] = (v[i/N] <  v[i%N]);
    end
  endtask

  logic [P-1:0] m_eq = '0, m_gt = '0, m_lt = '0;
  string        m_tag = "R10";
  always @(posedge clk) begin
    logic [P-1:0] e, g, l;
    ref_words(pts, e, g, l);
    if (rst) begin
      m_eq <= '0; m_gt <= '0; m_lt <= '0; m_tag <= "R10";
    end else if (upd_en) begin
      m_eq <= e; m_gt <= g; m_lt <= l; m_tag <= "R8";
    end else begin
      m_tag <= "R9";
    end
  end

  task automatic chk(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_registered();
    chk({m_tag, " eq R2"}, eq_r, m_eq);
    chk({m_tag, " gt R3"}, gt_r, m_gt);
    chk({m_tag, " lt R4"}, lt_r, m_lt);
  endtask

  task automatic check_comb();
    logic [P-1:0] e, g, l, mir, diag;
    ref_words(pts, e, g, l);
    chk("R11 eq R2", eq_c, e);
    chk("R11 gt R3", gt_c, g);
    chk("R11 lt R4", lt_c, l);
    checks++;
    for (int i = 0; i < P; i++)
      if ((eq_c[i] + gt_c[i] + lt_c[i]) != 1) begin
        errors++;
        $display("FAIL R5 bit %0d actual=%b%b%b expected one-hot", i, eq_c[i], gt_c[i], lt_c[i]);
      end
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) mir[a*N+b] = lt_c[b*N+a];
    chk("R7 gt vs mirrored lt", gt_c, mir);
    diag = {eq_c[15], gt_c[15], lt_c[15], eq_c[10], gt_c[10], lt_c[10],
            eq_c[5], gt_c[5], lt_c[5], eq_c[0], gt_c[0], lt_c[0], 4'b0000};
    chk("R6 diagonal", diag, 16'h9240);
  endtask

  function automatic logic [W-1:0] pick();
    int r = int'($urandom % 8);
    int v;
    if (r < 4) v = int'($urandom % 5) - 2;
    else if (r == 4) v = -2048;
    else if (r == 5) v = 2047;
    else v = int'($urandom % 4096) - 2048;
    return v[W-1:0];
  endfunction

  task automatic set_pts(input int p0, input int p1, input int p2, input int p3);
    pts = {p3[W-1:0], p2[W-1:0], p1[W-1:0], p0[W-1:0]};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset eq", eq_r, '0);
    chk("R10 reset gt", gt_r, '0);
    chk("R10 reset lt", lt_r, '0);
    rst = 1'b0;

    // R1: only point 2 differs
    set_pts(0, 0, 5, 0); #1;
    chk("R1 gt field order", gt_c, 16'h0B00);
    chk("R1 lt field order", lt_c, 16'h4044);
    // R4: negative below zero
    set_pts(-1, 0, -2048, 2047); #1;
    check_comb();
    checks++;
    if (!lt_c[1] || !gt_c[4] || !lt_c[2*4+3]) begin
      errors++;
      $display("FAIL R4 signed order actual lt=%h gt=%h expected lt[1],gt[4],lt[11] set", lt_c, gt_c);
    end
    // all equal: single point
    set_pts(7, 7, 7, 7); #1;
    chk("R2 all equal", eq_c, 16'hFFFF);
    upd_en = 1'b1;
    @(negedge clk); check_registered();
    // R9 directed hold with changing input
    upd_en = 1'b0; set_pts(1, 2, 3, 4);
    @(negedge clk); check_registered();
    chk("R9 hold eq", eq_r, 16'hFFFF);
    // R10 priority over enable
    upd_en = 1'b1; rst = 1'b1;
    @(negedge clk); check_registered();
    chk("R10 priority", eq_r, '0);
    rst = 1'b0;

    for (int cyc = 0; cyc < 2000; cyc++) begin
      for (int k = 0; k < N; k++) pts[k*W +: W] = pick();
      if ($urandom % 7 == 0) pts[2*W +: W] = pts[0 +: W];
      upd_en = ($urandom % 4) != 0;
      rst = ($urandom % 60) == 0;
      #1 check_comb();
      @(negedge clk);
      check_registered();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule